// File: doc/BRIEF.md
# Advanced Load Tracking Table

This block is a small fully associative table that records speculative (advanced) loads. When a load is hoisted above stores, the pipeline writes an entry tagged with the destination register: integer or floating, plus the register number. The entry also holds the physical address and access size that were read. Before the speculative value is used, a check asks whether the tag is still present. Any store whose byte range overlaps a recorded range removes that entry, so a miss tells the pipeline to reload.

One request port carries a single operation per cycle:
- write or allocate an entry;
- look up a register tag;
- invalidate the entry for one register tag;
- invalidate every entry that overlaps an address range.

A separate clear input empties the whole table and may arrive in the same cycle as a write. A lookup answers combinationally in the cycle of the request, from the table as it stands before that clock edge. Every update takes effect at the clock edge.

Top module: `adv_load_tracker`

## Requirements
- R1: While rst_ni is low, and after it is released, every entry is invalid, so every lookup misses.
- R2: With op_i = 2 (lookup), hit_o is 1 in the same cycle exactly when a valid entry has the same register kind (reg_fp_i, 1 = floating) and the same register number. A tag that differs in either field misses.
- R3: The table never holds two valid entries for the same register tag. A write to a tag that is already present reuses that entry and allocates no new slot.
- R4: A write (op_i = 1) to a tag that is already present always replaces the stored address and size with the new ones. Afterwards only the new range can invalidate the entry.
- R5: With op_i = 3, the entry whose tag matches is invalidated. All other entries are kept.
- R6: With op_i = 4, every entry whose range [addr, addr+bytes) overlaps the given range is invalidated. Two ranges overlap when each one starts below the end of the other, so ranges that only touch do not overlap. size_i is a byte-count code: 0 means 1 byte, 1 means 2, 2 means 4, 3 means 8, and 4 to 7 mean 16.
- R7: clr_all_i = 1 invalidates every entry at the next edge.
- R8: When clr_all_i and a write arrive in the same cycle, the clear happens first. The write's tag is then the only valid entry.
- R9: A write to a new tag takes the lowest-numbered free slot. When no slot is free, it replaces the slot named by a round-robin pointer. The pointer starts at 0 after reset and advances by one, wrapping, on every write that allocates a new slot.
- R10: op_i = 0 and the unused codes 5 to 7 change nothing and give hit_o = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_i | input | 3 | Operation: 0 none, 1 write, 2 lookup, 3 invalidate by register, 4 invalidate by address |
| clr_all_i | input | 1 | Invalidate every entry |
| reg_fp_i | input | 1 | Register kind: 0 integer, 1 floating |
| reg_num_i | input | REG_W (7) | Register number |
| paddr_i | input | PA_W (32) | Physical start address |
| size_i | input | 3 | Access size code |
| hit_o | output | 1 | Lookup result |

## Verification
The assertions check, on every cycle, the properties that never change:
- no tag is held twice;
- each write leaves its fields stored in exactly one selected slot;
- a killed entry goes invalid;
- a clear empties the table, or leaves only the write that arrived with it;
- hit_o is raised only for a lookup.

The bench scenarios show the rest:
- the exact overlap boundaries, including touching ranges and the 16-byte size codes;
- in-place replacement of the address on a rewrite;
- which entry the round-robin victim choice removes once the table is full;
- that unused op codes leave the contents intact.

// File: rtl/alt_pkg.sv
`timescale 1ns/1ps
package alt_pkg;

  typedef enum logic [2:0] {
    OP_NONE     = 3'd0,
    OP_WRITE    = 3'd1,
    OP_LOOKUP   = 3'd2,
    OP_INV_REG  = 3'd3,
    OP_INV_ADDR = 3'd4
  } alt_op_e;

  // size code -> byte count; codes above 4 saturate at 16
  function automatic logic [4:0] size_bytes(input logic [2:0] code);
    logic [4:0] b;
    case (code)
      3'd0: b = 5'd1;
      3'd1: b = 5'd2;
      3'd2: b = 5'd4;
      3'd3: b = 5'd8;
      default: b = 5'd16;
    endcase
    return b;
  endfunction

endpackage

// File: rtl/alt_entry.sv
`timescale 1ns/1ps
module alt_entry #(
  parameter int PA_W  = 32,
  parameter int REG_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic             kill_i,
  input  logic             fp_i,
  input  logic [REG_W-1:0] num_i,
  input  logic [PA_W-1:0]  addr_i,
  input  logic [2:0]       size_i,
  output logic             valid_o,
  output logic             tag_hit_o,
  output logic             ovl_o
);
  import alt_pkg::*;

  localparam int END_W = PA_W + 1;

  logic             valid_q;
  logic             fp_q;
  logic [REG_W-1:0] num_q;
  logic [PA_W-1:0]  addr_q;
  logic [2:0]       size_q;
  logic [END_W-1:0] e_start, e_end, q_start, q_end;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      fp_q    <= 1'b0;
      num_q   <= '0;
      addr_q  <= '0;
      size_q  <= '0;
    end else if (wr_i) begin
      valid_q <= 1'b1;
      fp_q    <= fp_i;
      num_q   <= num_i;
      addr_q  <= addr_i;
      size_q  <= size_i;
    end else if (kill_i) begin
      valid_q <= 1'b0;
    end
  end

  always_comb begin
    e_start = {1'b0, addr_q};
    e_end   = e_start + END_W'(size_bytes(size_q));
    q_start = {1'b0, addr_i};
    q_end   = q_start + END_W'(size_bytes(size_i));
  end

  assign valid_o   = valid_q;
  assign tag_hit_o = valid_q && (fp_q == fp_i) && (num_q == num_i);
  assign ovl_o     = valid_q && (e_start < q_end) && (q_start < e_end);

  // R4: a written slot holds exactly the written fields
  a_r4_write_stores: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> (valid_q && fp_q == $past(fp_i) && num_q == $past(num_i)
              && addr_q == $past(addr_i) && size_q == $past(size_i)));

  // R5: a killed slot without a write goes invalid
  a_r5_kill_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kill_i && !wr_i) |=> !valid_q);

endmodule

// File: rtl/alt_alloc.sv
`timescale 1ns/1ps
module alt_alloc #(
  parameter int DEPTH = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             alloc_req_i,
  input  logic             clr_all_i,
  input  logic [DEPTH-1:0] valid_i,
  input  logic [DEPTH-1:0] tag_hit_i,
  output logic [DEPTH-1:0] sel_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] PTR_MAX = PTR_W'(DEPTH - 1);

  logic [PTR_W-1:0] ptr_q;
  logic [DEPTH-1:0] free_v, hit_v, low_free, victim;
  logic             any_free, any_hit, new_alloc;

  always_comb begin
    // a same-cycle clear empties the table before the write lands
    free_v   = clr_all_i ? '1 : ~valid_i;
    hit_v    = clr_all_i ? '0 : tag_hit_i;
    any_hit  = |hit_v;
    any_free = |free_v;
    low_free = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (free_v[i]) begin
        low_free    = '0;
        low_free[i] = 1'b1;
      end
    end
    victim        = '0;
    victim[ptr_q] = 1'b1;
    if (!alloc_req_i)  sel_o = '0;
    else if (any_hit)  sel_o = hit_v;
    else if (any_free) sel_o = low_free;
    else               sel_o = victim;
    new_alloc = alloc_req_i && !any_hit;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ptr_q <= '0;
    else if (new_alloc) ptr_q <= (ptr_q == PTR_MAX) ? '0 : ptr_q + 1'b1;
  end

  // R9: one slot chosen per write, none otherwise
  a_r9_sel_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc_req_i |-> ($countones(sel_o) == 1));
  a_r9_sel_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !alloc_req_i |-> (sel_o == '0));
  a_r9_ptr_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ptr_q <= PTR_MAX);

endmodule

// File: rtl/adv_load_tracker.sv
`timescale 1ns/1ps
module adv_load_tracker #(
  parameter int DEPTH = 16,
  parameter int PA_W  = 32,
  parameter int REG_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [2:0]       op_i,
  input  logic             clr_all_i,
  input  logic             reg_fp_i,
  input  logic [REG_W-1:0] reg_num_i,
  input  logic [PA_W-1:0]  paddr_i,
  input  logic [2:0]       size_i,
  output logic             hit_o
);
  import alt_pkg::*;

  alt_op_e          op;
  logic             is_wr, is_lookup, is_inv_reg, is_inv_addr;
  logic [DEPTH-1:0] valid_v, tag_hit_v, ovl_v, sel_v, kill_v;

  always_comb begin
    op          = alt_op_e'(op_i);
    is_wr       = (op == OP_WRITE);
    is_lookup   = (op == OP_LOOKUP);
    is_inv_reg  = (op == OP_INV_REG);
    is_inv_addr = (op == OP_INV_ADDR);
  end

  alt_alloc #(.DEPTH(DEPTH)) i_alloc (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .alloc_req_i (is_wr),
    .clr_all_i   (clr_all_i),
    .valid_i     (valid_v),
    .tag_hit_i   (tag_hit_v),
    .sel_o       (sel_v)
  );

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    assign kill_v[g] = clr_all_i | (is_inv_reg & tag_hit_v[g]) | (is_inv_addr & ovl_v[g]);

    alt_entry #(.PA_W(PA_W), .REG_W(REG_W)) i_entry (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_i      (sel_v[g]),
      .kill_i    (kill_v[g]),
      .fp_i      (reg_fp_i),
      .num_i     (reg_num_i),
      .addr_i    (paddr_i),
      .size_i    (size_i),
      .valid_o   (valid_v[g]),
      .tag_hit_o (tag_hit_v[g]),
      .ovl_o     (ovl_v[g])
    );
  end

  assign hit_o = is_lookup & (|tag_hit_v);

  // R3: no tag held twice, whatever tag is presented
  a_r3_unique_tag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(tag_hit_v) <= 1);

  // R7: a lone clear empties the table
  a_r7_clear_all: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_all_i && !is_wr) |=> (valid_v == '0));

  // R8: clear plus write leaves one entry
  a_r8_clear_then_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_all_i && is_wr) |=> ($countones(valid_v) == 1));

  // R10: only a lookup raises hit_o
  a_r10_hit_only_lookup: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> (op_i == 3'd2));

endmodule

// File: tb/test_adv_load_tracker.sv
`timescale 1ns/1ps
module test_adv_load_tracker;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [2:0] op_i = '0;
  logic       clr_all_i = 1'b0;
  logic       reg_fp_i = 1'b0;
  logic [6:0] reg_num_i = '0;
  logic [31:0] paddr_i = '0;
  logic [2:0] size_i = '0;
  logic       hit_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  adv_load_tracker i_adv_load_tracker (
    .clk_i(clk), .rst_ni(rst_ni), .op_i(op_i), .clr_all_i(clr_all_i),
    .reg_fp_i(reg_fp_i), .reg_num_i(reg_num_i), .paddr_i(paddr_i),
    .size_i(size_i), .hit_o(hit_o)
  );

  typedef struct packed {
    logic [2:0]  op;
    logic        clr;
    logic        fp;
    logic [6:0]  num;
    logic [15:0] addr;
    logic [2:0]  sz;
    logic        chk;
    logic        exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 34;
  localparam vec_t VEC [NV] = '{
    '{3'd2, 1'b0, 1'b0, 7'd5,  16'h0000, 3'd0, 1'b1, 1'b0, 4'd1},  // R1 empty
    '{3'd1, 1'b0, 1'b0, 7'd5,  16'h0100, 3'd3, 1'b0, 1'b0, 4'd0},
    '{3'd2, 1'b0, 1'b0, 7'd5,  16'h0000, 3'd0, 1'b1, 1'b1, 4'd2},  // R2 hit
    '{3'd2, 1'b0, 1'b1, 7'd5,  16'h0000, 3'd0, 1'b1, 1'b0, 4'd2},  // R2 kind differs
    '{3'd2, 1'b0, 1'b0, 7'd6,  16'h0000, 3'd0, 1'b1, 1'b0, 4'd2},  // R2 number differs
    '{3'd1, 1'b0, 1'b1, 7'd5,  16'h0200, 3'd2, 1'b0, 1'b0, 4'd0},
    '{3'd2, 1'b0, 1'b1, 7'd5,  16'h0000, 3'd0, 1'b1, 1'b1, 4'd2},
    '{3'd4, 1'b0, 1'b0, 7'd0,  16'h0108, 3'd3, 1'b0, 1'b0, 4'd0},  // touching range
    '{3'd2, 1'b0, 1'b0, 7'd5,  16'h0000, 3'd0, 1'b1, 1'b1, 4'd6},  // R6 kept
    '{3'd4, 1'b0, 1'b0, 7'd0,  16'h00FF, 3'd1, 1'b0, 1'b0, 4'd0},  // covers first byte
    '{3'd2, 1'b0, 1'b0, 7'd5,  16'h0000, 3'd0, 1'b1, 1'b0, 4'd6},  // R6 cleared
    '{3'd2, 1'b0, 1'b1, 7'd5,  16'h0000, 3'd0, 1'b1, 1'b1, 4'd6},  // R6 other kept
    '{3'd1, 1'b0, 1'b0, 7'd7,  16'h0300, 3'd0, 1'b0, 1'b0, 4'd0},
    '{3'd3, 1'b0, 1'b1, 7'd5,  16'h0000, 3'd0, 1'b0, 1'b0, 4'd0},
    '{3'd2, 1'b0, 1'b0, 7'd7,  16'h0000, 3'd0, 1'b1, 1'b1, 4'd5},  // R5 others kept
    '{3'd2, 1'b0, 1'b1, 7'd5,  16'h0000, 3'd0, 1'b1, 1'b0, 4'd5},  // R5 target gone
    '{3'd1, 1'b0, 1'b0, 7'd9,  16'h0400, 3'd4, 1'b0, 1'b0, 4'd0},
    '{3'd1, 1'b0, 1'b0, 7'd9,  16'h0800, 3'd0, 1'b0, 1'b0, 4'd0},  // rewrite
    '{3'd4, 1'b0, 1'b0, 7'd0,  16'h0408, 3'd0, 1'b0, 1'b0, 4'd0},  // old range
    '{3'd2, 1'b0, 1'b0, 7'd9,  16'h0000, 3'd0, 1'b1, 1'b1, 4'd4},  // R4 old range inert
    '{3'd4, 1'b0, 1'b0, 7'd0,  16'h0800, 3'd0, 1'b0, 1'b0, 4'd0},  // new range
    '{3'd2, 1'b0, 1'b0, 7'd9,  16'h0000, 3'd0, 1'b1, 1'b0, 4'd4},  // R4 new range kills
    '{3'd7, 1'b0, 1'b0, 7'd7,  16'h0300, 3'd0, 1'b1, 1'b0, 4'd10}, // R10 no hit
    '{3'd5, 1'b0, 1'b0, 7'd7,  16'h0300, 3'd0, 1'b0, 1'b0, 4'd0},
    '{3'd2, 1'b0, 1'b0, 7'd7,  16'h0000, 3'd0, 1'b1, 1'b1, 4'd10}, // R10 intact
    '{3'd0, 1'b1, 1'b0, 7'd0,  16'h0000, 3'd0, 1'b0, 1'b0, 4'd0},
    '{3'd2, 1'b0, 1'b0, 7'd7,  16'h0000, 3'd0, 1'b1, 1'b0, 4'd7},  // R7 cleared
    '{3'd1, 1'b0, 1'b0, 7'd12, 16'h0500, 3'd0, 1'b0, 1'b0, 4'd0},
    '{3'd1, 1'b1, 1'b0, 7'd11, 16'h0600, 3'd0, 1'b0, 1'b0, 4'd0},  // clear + write
    '{3'd2, 1'b0, 1'b0, 7'd12, 16'h0000, 3'd0, 1'b1, 1'b0, 4'd8},  // R8 old gone
    '{3'd2, 1'b0, 1'b0, 7'd11, 16'h0000, 3'd0, 1'b1, 1'b1, 4'd8},  // R8 write kept
    '{3'd1, 1'b0, 1'b0, 7'd13, 16'h0700, 3'd7, 1'b0, 1'b0, 4'd0},  // code 7 = 16 bytes
    '{3'd4, 1'b0, 1'b0, 7'd0,  16'h070F, 3'd0, 1'b0, 1'b0, 4'd0},
    '{3'd2, 1'b0, 1'b0, 7'd13, 16'h0000, 3'd0, 1'b1, 1'b0, 4'd6}   // R6 last byte
  };

  task automatic drive(input logic [2:0] op, input logic clr, input logic fp,
                       input logic [6:0] num, input logic [31:0] addr, input logic [2:0] sz);
    @(negedge clk);
    op_i = op; clr_all_i = clr; reg_fp_i = fp; reg_num_i = num; paddr_i = addr; size_i = sz;
  endtask

  task automatic check_lk(input logic fp, input logic [6:0] num, input logic exp, input string rq);
    drive(3'd2, 1'b0, fp, num, 32'h0, 3'd0);
    #1;
    checks++;
    if (hit_o !== exp) begin
      fails++;
      $display("FAIL %s lookup fp=%0b reg=%0d: hit_o=%0b expected %0b", rq, fp, num, hit_o, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0; op_i = '0; clr_all_i = 1'b0;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    for (int v = 0; v < NV; v++) begin
      drive(VEC[v].op, VEC[v].clr, VEC[v].fp, VEC[v].num, {16'h0, VEC[v].addr}, VEC[v].sz);
      #1;
      if (VEC[v].chk) begin
        checks++;
        if (hit_o !== VEC[v].exp) begin
          fails++;
          $display("FAIL R%0d vector %0d: hit_o=%0b expected %0b", VEC[v].req, v, hit_o, VEC[v].exp);
        end
      end
    end

    // R9 / R3: fill, then round-robin eviction
    do_reset();
    check_lk(1'b0, 7'd0, 1'b0, "R1");
    for (int k = 0; k < 16; k++)
      drive(3'd1, 1'b0, 1'b0, 7'(k), 32'h1000 + 32'(k * 16), 3'd0);
    check_lk(1'b0, 7'd15, 1'b1, "R9");
    drive(3'd1, 1'b0, 1'b0, 7'd3, 32'h2000, 3'd0);   // in-place, pointer stays 0
    drive(3'd1, 1'b0, 1'b0, 7'd20, 32'h3000, 3'd0);  // evicts slot 0
    check_lk(1'b0, 7'd0, 1'b0, "R9");
    check_lk(1'b0, 7'd3, 1'b1, "R3");
    check_lk(1'b0, 7'd15, 1'b1, "R3");
    check_lk(1'b0, 7'd20, 1'b1, "R9");
    drive(3'd1, 1'b0, 1'b0, 7'd21, 32'h3100, 3'd0);  // evicts slot 1
    check_lk(1'b0, 7'd1, 1'b0, "R9");
    check_lk(1'b0, 7'd2, 1'b1, "R9");
    drive(3'd3, 1'b0, 1'b0, 7'd3, 32'h0, 3'd0);
    check_lk(1'b0, 7'd3, 1'b0, "R3");

    // R1: reset mid-run
    do_reset();
    check_lk(1'b0, 7'd15, 1'b0, "R1");
    check_lk(1'b0, 7'd20, 1'b0, "R1");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule